// File: doc/BRIEF.md
# Cyclic-Code Frame Lock and Sync Header Restorer

This block sits on the receive side of a backplane link that protects 64b/66b traffic with a shortened binary cyclic code. The incoming stream is already aligned to 65-bit words, but the receiver does not know where each protected frame begins. A frame takes WORDS+1 word slots. The first WORDS slots each carry one transcoded block, and the last slot carries the 32 check bits in bits 31:0. The block runs a 32-bit remainder over every candidate frame and compares it with the received check bits. It uses the pass or fail result of each frame to find the frame boundary and to hold it.

While hunting, every failed candidate moves the assumed boundary one slot later. Once enough frames in a row have passed, the block declares lock. From then on it turns every data slot back into a 66-bit block. To do this it recovers the second sync bit from the transcode bit and the received payload bit D8, and restores the first sync bit as the inverse of the second. Frames whose remainder does not match are flagged, but their contents are passed through unchanged. Enough failures in a row drop the lock, and the hunt starts again.

Top module: `fcl_frame_lock`

## Requirements
- R1: A frame passes when the remainder of its data bits, divided by x^32+x^23+x^21+x^11+x^2+1 after multiplication by x^32, equals bits 31:0 of its check slot. The division starts from zero. The data bits are taken slot by slot, and within a slot from bit 0 upward, with the first bit as the highest-degree term. Remainder bit 31 is the coefficient of x^31. Bits 64:32 of the check slot are ignored.
- R2: While unlocked, `locked` rises in the cycle after the check slot of the LOCK_GOOD-th passing frame in a row (default 4).
- R3: While unlocked, a failed frame makes the block discard the next valid word. The following candidate frame therefore starts one slot later. Starting from any offset of the true boundary, the block reaches lock.
- R4: While locked, each accepted data slot produces `blk_vld` high for one cycle in the next cycle. Check slots produce no block.
- R5: A produced block has bit 0 = S0, bit 1 = S1 and bits 65:2 = payload bits D0..D63, taken from input bits 64:1. S1 is input bit 0 XOR input bit 9 (the received D8), and S0 is the inverse of S1.
- R6: While locked, a failed frame makes `synd_err` pulse for the one cycle after its check slot. The data of that frame is still delivered.
- R7: While locked, `locked` falls in the cycle after the check slot of the LOSS_BAD-th failed frame in a row (default 8). Any passing frame restarts that count.
- R8: `blk_vld` stays low while unlocked. Whenever `blk_vld` is low, `blk_data` keeps its previous value, including in the cycle after a boundary slip.
- R9: After reset, `locked`, `blk_vld` and `synd_err` are low and `blk_data` is zero.
- R10: A cycle with `in_vld` low advances nothing: no slot is counted, no block is produced, and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Word on `in_word` is valid this cycle |
| in_word | input | 65 | Received word: transcode bit in bit 0, payload in bits 64:1, or check bits in 31:0 |
| blk_vld | output | 1 | `blk_data` holds a new restored block |
| blk_data | output | 66 | Restored 64b/66b block, sync bits in 1:0 |
| locked | output | 1 | Frame boundary acquired |
| synd_err | output | 1 | One-cycle flag for a failed frame while locked |

## Verification
The bench starts the true frame boundary at every possible slot offset. For each offset it predicts the exact word after which lock must appear and the first block that must come out. A design that slipped by the wrong amount, or did not slip at all, would lock late, lock never, or emit blocks from the wrong frame. A second run corrupts D8 in some frames while locked. A design that rebuilt S1 from the transcode bit alone would then produce wrong sync bits. The same run checks that a single good frame in a run of failures keeps the lock, because a design that never restarted the failure count would drop lock early. Idle cycles inside frames would shift the slot count of a design that counted clock cycles instead of valid words.

// File: rtl/fcl_pkg.sv
package fcl_pkg;
  localparam int XW      = 65;             // transcoded word width
  localparam int BLK_W   = 66;             // restored block width
  localparam int PAR_W   = 32;             // check bits per frame
  localparam int MIX_POS = 9;              // word bit holding payload D8
  localparam logic [PAR_W-1:0] GEN_TAPS = 32'h00A0_0805; // g(x) without x^32

  // Advance the remainder register over one word, bit 0 first.
  function automatic logic [PAR_W-1:0] synd_step(input logic [PAR_W-1:0] crc,
                                                 input logic [XW-1:0]    w);
    logic [PAR_W-1:0] c;
    logic             fb;
    c = crc;
    for (int b = 0; b < XW; b++) begin
      fb = w[b] ^ c[PAR_W-1];
      c  = {c[PAR_W-2:0], 1'b0} ^ (fb ? GEN_TAPS : '0);
    end
    return c;
  endfunction

  // Undo the D8 mixing and rebuild both sync bits.
  function automatic logic [BLK_W-1:0] restore_block(input logic [XW-1:0] w);
    logic s1;
    s1 = w[0] ^ w[MIX_POS];
    return {w[XW-1:1], s1, ~s1};
  endfunction
endpackage

// File: rtl/fcl_synd.sv
module fcl_synd
  import fcl_pkg::*;
#(
  parameter int WORDS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [XW-1:0] in_word,
  input  logic          slip,
  output logic          accept,
  output logic          is_data,
  output logic          frame_done,
  output logic          frame_ok
);
  localparam int SLOT_W = $clog2(WORDS + 1);

  logic [SLOT_W-1:0] slot_q;
  logic [PAR_W-1:0]  crc_q;
  logic              skip_q;

  always_comb begin
    accept     = in_vld & ~skip_q;
    frame_done = accept & (slot_q == SLOT_W'(WORDS));
    is_data    = accept & ~frame_done;
    frame_ok   = (crc_q == in_word[PAR_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      crc_q  <= '0;
      skip_q <= 1'b0;
    end else begin
      if (slip)        skip_q <= 1'b1;
      else if (in_vld) skip_q <= 1'b0;

      if (frame_done) begin
        slot_q <= '0;
        crc_q  <= '0;
      end else if (accept) begin
        slot_q <= slot_q + 1'b1;
        crc_q  <= synd_step(crc_q, in_word);
      end
    end
  end
endmodule

// File: rtl/fcl_lock.sv
module fcl_lock #(
  parameter int LOCK_GOOD = 4,
  parameter int LOSS_BAD  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_done,
  input  logic frame_ok,
  output logic locked,
  output logic slip,
  output logic synd_err
);
  localparam int GOOD_W = $clog2(LOCK_GOOD + 1);
  localparam int BAD_W  = $clog2(LOSS_BAD + 1);

  logic [GOOD_W-1:0] good_q;
  logic [BAD_W-1:0]  bad_q;
  logic              locked_q;
  logic              fail, gain, lose;

  always_comb begin
    fail = frame_done & ~frame_ok;
    gain = ~locked_q & frame_done & frame_ok & (good_q == GOOD_W'(LOCK_GOOD - 1));
    lose = locked_q & fail & (bad_q == BAD_W'(LOSS_BAD - 1));
    slip = fail & (~locked_q | lose);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      good_q   <= '0;
      bad_q    <= '0;
      locked_q <= 1'b0;
      synd_err <= 1'b0;
    end else begin
      synd_err <= fail & locked_q;
      if (frame_done) begin
        if (locked_q) begin
          good_q <= '0;
          if (frame_ok)  bad_q <= '0;
          else if (lose) begin
            bad_q    <= '0;
            locked_q <= 1'b0;
          end else       bad_q <= bad_q + 1'b1;
        end else begin
          bad_q <= '0;
          if (!frame_ok) good_q <= '0;
          else if (gain) begin
            good_q   <= '0;
            locked_q <= 1'b1;
          end else       good_q <= good_q + 1'b1;
        end
      end
    end
  end

  assign locked = locked_q;
endmodule

// File: rtl/fcl_hdr.sv
module fcl_hdr
  import fcl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             emit,
  input  logic [XW-1:0]    in_word,
  output logic             blk_vld,
  output logic [BLK_W-1:0] blk_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_vld  <= 1'b0;
      blk_data <= '0;
    end else begin
      blk_vld <= emit;
      if (emit) blk_data <= restore_block(in_word);
    end
  end
endmodule

// File: rtl/fcl_frame_lock.sv
module fcl_frame_lock
  import fcl_pkg::*;
#(
  parameter int WORDS     = 32,
  parameter int LOCK_GOOD = 4,
  parameter int LOSS_BAD  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_vld,
  input  logic [64:0] in_word,
  output logic        blk_vld,
  output logic [65:0] blk_data,
  output logic        locked,
  output logic        synd_err
);
  // Named internal events, observed by the bound checker.
  logic accept, is_data, frame_done, frame_ok, slip, emit;

  fcl_synd #(.WORDS(WORDS)) u_synd (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_vld     (in_vld),
    .in_word    (in_word),
    .slip       (slip),
    .accept     (accept),
    .is_data    (is_data),
    .frame_done (frame_done),
    .frame_ok   (frame_ok)
  );

  fcl_lock #(.LOCK_GOOD(LOCK_GOOD), .LOSS_BAD(LOSS_BAD)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .frame_ok   (frame_ok),
    .locked     (locked),
    .slip       (slip),
    .synd_err   (synd_err)
  );

  assign emit = is_data & locked;

  fcl_hdr u_hdr (
    .clk      (clk),
    .rst_n    (rst_n),
    .emit     (emit),
    .in_word  (in_word),
    .blk_vld  (blk_vld),
    .blk_data (blk_data)
  );
endmodule

// File: rtl/fcl_frame_lock_chk.sv
module fcl_frame_lock_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        blk_vld,
  input logic [65:0] blk_data,
  input logic        locked,
  input logic        synd_err,
  input logic        frame_done,
  input logic        frame_ok,
  input logic        slip,
  input logic        accept
);
  p_vld_needs_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blk_vld |-> locked);
  p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_vld |-> $stable(blk_data));
  p_sync_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_vld |-> (blk_data[0] != blk_data[1]));
  p_err_while_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    synd_err |-> $past(locked));
  p_err_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    synd_err |=> !synd_err);
  p_lock_on_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(frame_done && frame_ok));
  p_loss_on_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(frame_done && !frame_ok));
  p_slip_skips_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slip |=> !accept);
endmodule

bind fcl_frame_lock fcl_frame_lock_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .blk_vld    (blk_vld),
  .blk_data   (blk_data),
  .locked     (locked),
  .synd_err   (synd_err),
  .frame_done (frame_done),
  .frame_ok   (frame_ok),
  .slip       (slip),
  .accept     (accept)
);

// File: tb/test_fcl_frame_lock.sv
module test_fcl_frame_lock;
  localparam int W = 4;          // data slots per frame in this configuration
  localparam int S = W + 1;      // slots per frame
  localparam int LOCK_N = 4;
  localparam int LOSS_N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [64:0] in_word = '0;
  logic        blk_vld, locked, synd_err;
  logic [65:0] blk_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [65:0] prev_data = '0;

  fcl_frame_lock #(.WORDS(W), .LOCK_GOOD(LOCK_N), .LOSS_BAD(LOSS_N)) i_fcl_frame_lock (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_word(in_word),
    .blk_vld(blk_vld), .blk_data(blk_data), .locked(locked), .synd_err(synd_err)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Original 66-bit block: [0]=S0, [1]=S1, [65:2]=D0..D63.
  function automatic logic [65:0] orig(int f, int i, int salt);
    int unsigned h;
    logic [63:0] d;
    logic s1;
    h  = f * 97 + i * 13 + salt * 7919 + 1;
    d  = {h * 32'h9E37_79B1, (h * 32'h85EB_CA77) ^ 32'h5BD1_E995};
    s1 = (i % 2 == 1) ^ ((f / 2) % 2 == 1);
    return {d, s1, ~s1};
  endfunction

  // Transmit side: drop S0, send S1 mixed with D8 in bit 0.
  function automatic logic [64:0] txw(logic [65:0] b);
    return {b[65:2], b[1] ^ b[10]};
  endfunction

  // Polynomial long division of message * x^32 by g(x).
  function automatic logic [31:0] par_of(int f);
    logic [32:0] r;
    logic [64:0] w;
    r = '0;
    for (int i = 0; i < W; i++) begin
      w = txw(orig(f, i, 0));
      for (int j = 0; j < 65; j++) begin
        r = {r[31:0], w[j]};
        if (r[32]) r = r ^ 33'h1_00A0_0805;
      end
    end
    for (int j = 0; j < 32; j++) begin
      r = {r[31:0], 1'b0};
      if (r[32]) r = r ^ 33'h1_00A0_0805;
    end
    return r[31:0];
  endfunction

  task automatic chk(string tag, string what, logic [65:0] act, logic [65:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic v, input logic [64:0] w, input logic ev,
                      input logic [65:0] ed, input logic el, input logic ee,
                      input string tag);
    logic [65:0] exp_d;
    @(negedge clk);
    in_vld  = v;
    in_word = w;
    @(posedge clk);
    #1;
    exp_d = ev ? ed : prev_data;
    chk(tag, "blk_vld", 66'(blk_vld), 66'(ev));
    chk(tag, "locked", 66'(locked), 66'(el));
    chk(tag, "synd_err", 66'(synd_err), 66'(ee));
    chk(tag, "blk_data", blk_data, exp_d);
    prev_data = blk_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    in_vld = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    prev_data = '0;
  endtask

  initial begin
    // R9: reset state
    do_reset();
    #1;
    chk("R9", "blk_vld", 66'(blk_vld), 66'(0));
    chk("R9", "locked", 66'(locked), 66'(0));
    chk("R9", "synd_err", 66'(synd_err), 66'(0));
    chk("R9", "blk_data", blk_data, '0);

    // R1 R2 R3 R8: every boundary offset, exact lock point and first block
    for (int j = 0; j < S; j++) begin
      int k;
      int p;
      logic [64:0] w;
      logic [65:0] b;
      do_reset();
      k = 0;
      p = j + S * (j + 3) + W;   // check slot of 4th aligned frame after j slips
      for (int n = 0; n < j; n++) begin
        push(1'b1, txw(orig(n, 0, 5)), 1'b0, '0, 1'b0, 1'b0, "R1,R2,R3,R8");
        k++;
      end
      for (int f = 0; f < j + 6; f++) begin
        for (int i = 0; i < S; i++) begin
          b = orig(f, i, 0);
          w = (i == W) ? {33'b0, par_of(f)} : txw(b);
          push(1'b1, w, (k > p) && (i < W), b, k >= p, 1'b0, "R1,R2,R3,R8");
          k++;
        end
      end
    end

    // R4 R5 R6 R7 R10: corrupted D8, error flags, count restart, loss of lock
    begin
      logic lk;
      int gr;
      int br;
      logic e;
      logic badf;
      logic [64:0] w;
      logic [65:0] b;
      do_reset();
      lk = 1'b0; gr = 0; br = 0;
      for (int f = 0; f < 22; f++) begin
        badf = (f >= 6 && f <= 12) || (f >= 14);
        for (int i = 0; i < S; i++) begin
          b = orig(f, i, 0);
          if (i == W) begin
            e = 1'b0;
            if (lk) begin
              if (badf) begin
                e = 1'b1;
                br++;
                if (br == LOSS_N) begin lk = 1'b0; br = 0; end
              end else br = 0;
            end else begin
              if (!badf) begin
                gr++;
                if (gr == LOCK_N) begin lk = 1'b1; gr = 0; end
              end else gr = 0;
            end
            push(1'b1, {33'b0, par_of(f)}, 1'b0, '0, lk, e, "R6,R7");
          end else begin
            if (badf && i == 1) begin
              w = txw(b) ^ (65'h1 << 9);     // flip received D8
              b = b ^ 66'h403;               // D8, S1 and S0 all flip
            end else w = txw(b);
            push(1'b1, w, lk, b, lk, 1'b0, "R4,R5,R6");
            if (i == 2) push(1'b0, w ^ 65'h1F, 1'b0, '0, lk, 1'b0, "R10");
          end
        end
      end
      // R3 R8: word after loss is discarded, output holds
      push(1'b1, txw(orig(22, 0, 0)), 1'b0, '0, 1'b0, 1'b0, "R3,R8");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule